// File: doc/BRIEF.md
# Masked Level Interrupt Aggregator

This block gathers up to eight interrupt sources onto one level-sensitive request line for an upstream controller. Each source owns one bit of a pending register. Sources raise their bits by pulsing a post vector and drop them by pulsing a clear vector. A host programs an enable mask over a simple byte bus. In that mask a 1 lets the matching pending bit reach the line and a 0 holds it back. The host can also read back the pending bits and both mask registers.

The line is a registered level. Besides the level, the block gives a one-cycle pulse when the line rises and another when it falls, so upstream logic can count transitions. The line is only raised by a post or an enable-mask write, and only lowered by a clear. A mask write that leaves no enabled bit pending does not lower an active line; the next clear does. A second, auxiliary mask register is stored and readable, but it never touches the line.

Top module: `irq_agg`

## Requirements
- R1: A nonzero `post_vec` sets the matching pending bits (bitwise OR into pending) on the next clock edge.
- R2: A nonzero `clr_vec` clears the matching pending bits on the next edge. When a post and a clear name the same bit in one cycle, the clear wins and the bit ends up 0.
- R3: After a post or an enable-mask write, if (pending AND enable) is nonzero and the line is low, then `irq_o` goes high at that edge and `irq_rise_o` pulses for exactly that one cycle.
- R4: After a clear, if (pending AND enable) is zero and the line is high, then `irq_o` goes low at that edge and `irq_fall_o` pulses for exactly that one cycle.
- R5: While and after reset, pending, the enable mask and the auxiliary mask are 0x00, `irq_o` is low, and neither pulse is high.
- R6: A write to address 1 (auxiliary mask) stores the byte and makes it readable. It never changes `irq_o` or either pulse.
- R7: Read map on `bus_rdata`, combinational from `bus_addr`: 0 gives the enable mask, 1 the auxiliary mask, 2 the pending bits, 3 reads 0x00. Writes to addresses 2 and 3 are ignored. Bit i of the enable mask set to 1 enables source i.
- R8: An enable-mask write alone never lowers `irq_o`. An active line stays high until a clear leaves no enabled bit pending.
- R9: While `irq_o` is already high, a further post or mask write produces no `irq_rise_o` pulse. At most one of the two pulses is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| post_vec | input | N_SRC | Set strobes, one bit per source |
| clr_vec | input | N_SRC | Clear strobes, one bit per source |
| bus_addr | input | 2 | Register select for read and write |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq_o | output | 1 | Level interrupt to upstream |
| irq_rise_o | output | 1 | One-cycle pulse when the line goes high |
| irq_fall_o | output | 1 | One-cycle pulse when the line goes low |

## Verification
The bench builds the block with the default N_SRC of 8, so every source bit fills a byte lane. That lets the read-back paths and the auxiliary mask be checked on every bit position. Directed steps cover the ordering corner cases: a mask write that raises the line, a mask write that leaves it high, a post and a clear on the same bit in one cycle, and a post into an already active line. A long run of mixed random posts, clears and bus writes then compares the line, both pulses and the read data against a behavioural model on every clock.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    SEL_ENABLE = 2'd0,
    SEL_AUX    = 2'd1,
    SEL_PEND   = 2'd2,
    SEL_RSVD   = 2'd3
  } reg_sel_e;

  // next pending value: sets land first, clears are applied on top
  function automatic logic [DATA_W-1:0] pend_next_f(
    input logic [DATA_W-1:0] cur,
    input logic [DATA_W-1:0] set_v,
    input logic [DATA_W-1:0] clr_v
  );
    return (cur | set_v) & ~clr_v;
  endfunction

  // true when any enabled source is pending
  function automatic logic any_enabled_f(
    input logic [DATA_W-1:0] pend,
    input logic [DATA_W-1:0] en
  );
    return |(pend & en);
  endfunction

endpackage

// File: rtl/irq_agg_pending.sv
module irq_agg_pending
  import irq_agg_pkg::*;
#(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] post_vec,
  input  logic [N_SRC-1:0] clr_vec,
  output logic [N_SRC-1:0] pend_q,
  output logic [N_SRC-1:0] pend_nxt,
  output logic             post_any,
  output logic             clr_any
);

  logic [DATA_W-1:0] nxt_wide;

  always_comb begin
    nxt_wide = pend_next_f(DATA_W'(pend_q), DATA_W'(post_vec), DATA_W'(clr_vec));
    pend_nxt = nxt_wide[N_SRC-1:0];
    post_any = |post_vec;
    clr_any  = |clr_vec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_nxt;
  end

endmodule

// File: rtl/irq_agg_regs.sv
module irq_agg_regs
  import irq_agg_pkg::*;
#(
  parameter int N_SRC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [N_SRC-1:0]  pend_q,
  output logic [N_SRC-1:0]  mask_q,
  output logic [N_SRC-1:0]  mask_nxt,
  output logic              mask_wr,
  output logic [DATA_W-1:0] aux_q,
  output logic [DATA_W-1:0] bus_rdata
);

  reg_sel_e sel;
  logic     aux_wr;

  always_comb begin
    sel      = reg_sel_e'(bus_addr);
    mask_wr  = bus_wr && (sel == SEL_ENABLE);
    aux_wr   = bus_wr && (sel == SEL_AUX);
    mask_nxt = mask_wr ? bus_wdata[N_SRC-1:0] : mask_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      aux_q  <= '0;
    end else begin
      mask_q <= mask_nxt;
      if (aux_wr) aux_q <= bus_wdata;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_ENABLE: bus_rdata = DATA_W'(mask_q);
      SEL_AUX:    bus_rdata = aux_q;
      SEL_PEND:   bus_rdata = DATA_W'(pend_q);
      default:    bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/irq_agg_line.sv
module irq_agg_line
  import irq_agg_pkg::*;
#(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             post_any,
  input  logic             clr_any,
  input  logic             mask_wr,
  input  logic [N_SRC-1:0] pend_nxt,
  input  logic [N_SRC-1:0] mask_nxt,
  output logic             line_q,
  output logic             rise_q,
  output logic             fall_q
);

  logic enabled_nxt;
  logic rise_ev;
  logic fall_ev;

  always_comb begin
    enabled_nxt = any_enabled_f(DATA_W'(pend_nxt), DATA_W'(mask_nxt));
    rise_ev     = (post_any || mask_wr) && enabled_nxt && !line_q;
    fall_ev     = clr_any && !enabled_nxt && line_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      rise_q <= rise_ev;
      fall_q <= fall_ev;
      if (rise_ev)      line_q <= 1'b1;
      else if (fall_ev) line_q <= 1'b0;
    end
  end

endmodule

// File: rtl/irq_agg.sv
module irq_agg
  import irq_agg_pkg::*;
#(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] post_vec,
  input  logic [N_SRC-1:0] clr_vec,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  output logic             irq_o,
  output logic             irq_rise_o,
  output logic             irq_fall_o
);

  logic [N_SRC-1:0]  pend_q;
  logic [N_SRC-1:0]  pend_nxt;
  logic [N_SRC-1:0]  mask_q;
  logic [N_SRC-1:0]  mask_nxt;
  logic [DATA_W-1:0] aux_q;
  logic              post_any;
  logic              clr_any;
  logic              mask_wr;

  irq_agg_pending #(.N_SRC(N_SRC)) pend_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .post_vec (post_vec),
    .clr_vec  (clr_vec),
    .pend_q   (pend_q),
    .pend_nxt (pend_nxt),
    .post_any (post_any),
    .clr_any  (clr_any)
  );

  irq_agg_regs #(.N_SRC(N_SRC)) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .pend_q    (pend_q),
    .mask_q    (mask_q),
    .mask_nxt  (mask_nxt),
    .mask_wr   (mask_wr),
    .aux_q     (aux_q),
    .bus_rdata (bus_rdata)
  );

  irq_agg_line #(.N_SRC(N_SRC)) line_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .post_any (post_any),
    .clr_any  (clr_any),
    .mask_wr  (mask_wr),
    .pend_nxt (pend_nxt),
    .mask_nxt (mask_nxt),
    .line_q   (irq_o),
    .rise_q   (irq_rise_o),
    .fall_q   (irq_fall_o)
  );

endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
  parameter int N_SRC = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] post_vec,
  input logic [N_SRC-1:0] clr_vec,
  input logic [1:0]       bus_addr,
  input logic             bus_wr,
  input logic [N_SRC-1:0] pend_q,
  input logic [N_SRC-1:0] mask_q,
  input logic             irq_o,
  input logic             irq_rise_o,
  input logic             irq_fall_o
);

  logic [N_SRC-1:0] set_only;
  assign set_only = post_vec & ~clr_vec;

  p_post_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_only) |=> ((pend_q & $past(set_only)) == $past(set_only)));

  p_clear_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_vec) |=> ((pend_q & $past(clr_vec)) == '0));

  p_rise_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rise_o |-> (irq_o && |(pend_q & mask_q)));

  p_rise_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rise_o |=> !irq_rise_o);

  p_fall_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_fall_o |-> (!irq_o && (pend_q & mask_q) == '0));

  p_idle_after_reset_r5: assert property (@(posedge clk)
    !rst_n |=> (!irq_o && !irq_rise_o && !irq_fall_o && pend_q == '0));

  p_aux_no_effect_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd1 && post_vec == '0 && clr_vec == '0)
      |=> ($stable(irq_o) && !irq_rise_o && !irq_fall_o));

  p_hold_without_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && clr_vec == '0) |=> irq_o);

  p_one_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_rise_o, irq_fall_o}));

endmodule

bind irq_agg irq_agg_chk #(.N_SRC(N_SRC)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .post_vec   (post_vec),
  .clr_vec    (clr_vec),
  .bus_addr   (bus_addr),
  .bus_wr     (bus_wr),
  .pend_q     (pend_q),
  .mask_q     (mask_q),
  .irq_o      (irq_o),
  .irq_rise_o (irq_rise_o),
  .irq_fall_o (irq_fall_o)
);

// File: tb/irq_agg_tb_top.sv
module irq_agg_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] post_vec = '0;
  logic [7:0] clr_vec = '0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq_o, irq_rise_o, irq_fall_o;

  int vectors = 0;
  int misses = 0;
  bit finished = 0;

  // behavioural reference state
  int m_pend = 0, m_en = 0, m_aux = 0;
  bit m_line = 0, m_rise = 0, m_fall = 0;

  always #5 clk = ~clk;

  irq_agg #(.N_SRC(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .post_vec(post_vec), .clr_vec(clr_vec),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o), .irq_rise_o(irq_rise_o),
    .irq_fall_o(irq_fall_o)
  );

  function automatic int read_model(input int a);
    if (a == 0) return m_en;
    if (a == 1) return m_aux;
    if (a == 2) return m_pend;
    return 0;
  endfunction

  task automatic compare(input string tag);
    int exp_rd;
    exp_rd = read_model(int'(bus_addr));
    vectors++;
    if (irq_o !== m_line) begin
      misses++;
      $display("FAIL %s line: got %0b expected %0b", tag, irq_o, m_line);
    end
    if (irq_rise_o !== m_rise) begin
      misses++;
      $display("FAIL %s rise pulse: got %0b expected %0b", tag, irq_rise_o, m_rise);
    end
    if (irq_fall_o !== m_fall) begin
      misses++;
      $display("FAIL %s fall pulse: got %0b expected %0b", tag, irq_fall_o, m_fall);
    end
    if (int'(bus_rdata) != exp_rd) begin
      misses++;
      $display("FAIL %s rdata@%0d: got %02h expected %02h", tag, bus_addr, bus_rdata, exp_rd);
    end
  endtask

  // apply one cycle of stimulus, advance the model, check after the edge
  task automatic step(input int post, input int clr, input int addr,
                      input bit wr, input int wdata, input string tag);
    int  new_pend, new_en;
    bit  any_on, touched;
    post_vec  = 8'(post);
    clr_vec   = 8'(clr);
    bus_addr  = 2'(addr);
    bus_wr    = wr;
    bus_wdata = 8'(wdata);
    new_pend = post | m_pend;
    for (int b = 0; b < 8; b++)
      if (clr[b]) new_pend[b] = 1'b0;
    new_pend = new_pend & 255;
    new_en = m_en;
    if (wr && addr == 0) new_en = wdata & 255;
    if (wr && addr == 1) m_aux = wdata & 255;
    any_on  = (new_pend & new_en) != 0;
    touched = (post != 0) || (wr && addr == 0);
    m_rise = 0;
    m_fall = 0;
    if (!m_line && touched && any_on) begin
      m_line = 1;
      m_rise = 1;
    end else if (m_line && clr != 0 && !any_on) begin
      m_line = 0;
      m_fall = 1;
    end
    m_pend = new_pend;
    m_en   = new_en;
    @(posedge clk);
    @(negedge clk);
    post_vec = '0;
    clr_vec  = '0;
    bus_wr   = 1'b0;
    compare(tag);
  endtask

  task automatic idle_read(input int addr, input string tag);
    step(0, 0, addr, 0, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R5: state during reset
    compare("R5 in reset");
    rst_n = 1'b1;
    idle_read(0, "R5 enable after reset");
    idle_read(1, "R5 aux after reset");
    idle_read(2, "R5 pending after reset");
    idle_read(3, "R7 reserved reads zero");

    // R1: post with everything disabled
    step(8'h04, 0, 2, 0, 0, "R1 post while disabled");
    step(8'h20, 0, 2, 0, 0, "R1 second post ORs in");
    // R3: mask write alone raises the line
    step(0, 0, 0, 1, 8'h04, "R3 mask write raises line");
    idle_read(0, "R3 pulse lasts one cycle");
    // R9: post into active line
    step(8'h01, 0, 2, 0, 0, "R9 no rise while active");
    step(0, 0, 0, 1, 8'h25, "R9 mask write while active");
    // R8: disable everything, line stays
    step(0, 0, 0, 1, 8'h00, "R8 mask to zero keeps line");
    idle_read(2, "R8 line still held");
    // R4: clear with nothing enabled drops line
    step(0, 8'h01, 2, 0, 0, "R4 clear drops line");
    idle_read(2, "R4 fall pulse one cycle");
    // R6: aux mask has no effect
    step(0, 0, 1, 1, 8'hFF, "R6 aux write stored");
    step(8'h80, 0, 1, 0, 0, "R6 post with aux set");
    // R7: writes to pending and reserved ignored
    step(0, 0, 2, 1, 8'h00, "R7 pending write ignored");
    step(0, 0, 3, 1, 8'hFF, "R7 reserved write ignored");
    idle_read(2, "R7 pending intact");
    // R2: same-cycle post and clear on one bit
    step(0, 8'hFF, 2, 0, 0, "R2 clear all");
    step(0, 0, 0, 1, 8'h10, "R2 enable bit4");
    step(8'h10, 8'h10, 2, 0, 0, "R2 clear beats post");
    step(8'h18, 8'h08, 2, 0, 0, "R2 mixed post and clear");
    step(8'h10, 8'h10, 2, 0, 0, "R2 collision on active line");
    // R3: post raising line directly, then R4 clear of enabled bit
    step(0, 8'hFF, 2, 0, 0, "R4 clear enabled bit");
    step(8'h10, 0, 2, 0, 0, "R3 post raises line");
    step(8'h02, 8'h10, 2, 0, 0, "R4 clear with unrelated post");

    // mixed random traffic
    for (int i = 0; i < 2000; i++) begin
      int p, c, a, w, d;
      p = (($urandom % 4) == 0) ? int'($urandom % 256) : 0;
      c = (($urandom % 4) == 0) ? int'($urandom % 256) : 0;
      a = int'($urandom % 4);
      w = (($urandom % 5) == 0) ? 1 : 0;
      d = int'($urandom % 256);
      step(p, c, a, w[0], d, "R9 random mix");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule